// File: doc/BRIEF.md
# Dual-Clock FIFO with Fill-Level Compare and Parity

This block carries data words from a write clock domain to an unrelated read clock domain. Each side keeps a binary pointer one bit wider than the storage address. The pointer crosses to the other domain in Gray code through a multi-flop synchronizer. The read side computes EMPTY from its own pointer and the synchronized write pointer. The write side computes FULL from its own pointer and the synchronized read pointer. The write side also derives a fill level from the same two values. It compares that level against a static threshold input and drives two flags: one for an exact match and one for "at or above".

A write is strobed by two active-low inputs that must both be low: a write request and a write block. The write side ignores every write strobe after reset until it has seen the strobe inactive on at least one write-clock edge. A strobe that is still low when reset releases therefore writes nothing. Writes that arrive while FULL is set are dropped. A read frees space, and the next write becomes legal as soon as the freed slot has crossed the synchronizer.

A parity bit can be stored with each word. With the generate-parity input set, the block computes even parity over the data word, stores it, and holds the parity-error output low. With the input clear, the block stores the parity bit supplied with the word, and the error output shows a mismatch between that bit and the data. The read side presents the oldest word at its outputs whenever EMPTY is low (first-word fall-through).

Top module: `afifo_thresh`

## Requirements
- R1: While `empty` is 0, `rd_data` and `rd_par` show the oldest unread word. A read (`rd_n` low at a rising `rclk` edge while `empty` is 0) removes it. Words leave in the order they were written.
- R2: A write occurs at a rising `wclk` edge only when `wr_n` and `wr_blk_n` are both 0. If either one is 1, nothing is stored and the fill level does not change.
- R3: A write attempted while `full` is 1 is dropped. The stored words and their order are unchanged.
- R4: `empty` is 1 after reset and again once every written word has been read. A read while `empty` is 1 has no effect.
- R5: `full` is 1 when the write-side fill level equals the depth 2**ADDR_W, and it is 0 otherwise.
- R6: The write-side fill level is written words minus synchronized read count. `eq_th` is 1 exactly when that level equals `thresh`. `ge_th` is 1 exactly when it is greater than or equal to `thresh`.
- R7: After reset, no write is accepted until the combined strobe (`wr_n` OR `wr_blk_n`) has been 1 on at least one rising `wclk` edge. A strobe held low through reset release stores nothing.
- R8: With `par_gen` = 1, the block stores the stored parity bit as the XOR of all `wr_data` bits (even parity), whatever `wr_par` is. `wr_par_err` is 0.
- R9: With `par_gen` = 0, the block stores `wr_par` as given. `wr_par_err` is the XOR of all `wr_data` bits XOR `wr_par`, combinationally from the inputs.
- R10: After a read frees a slot in a full FIFO, `full` returns to 0 within SYNC_STAGES+1 `wclk` cycles, and the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_n | input | 1 | Active-low write request |
| wr_blk_n | input | 1 | Active-low write block; must also be low for a write |
| wr_data | input | DATA_W | Write data word |
| wr_par | input | 1 | Parity bit supplied with the word (used when par_gen = 0) |
| par_gen | input | 1 | 1: generate parity internally; 0: check supplied parity |
| thresh | input | ADDR_W+1 | Fill-level threshold |
| rd_n | input | 1 | Active-low read request |
| rd_data | output | DATA_W | Oldest stored word |
| rd_par | output | 1 | Parity bit stored with the oldest word |
| empty | output | 1 | No word available (read domain) |
| full | output | 1 | Storage full (write domain) |
| eq_th | output | 1 | Fill level equals thresh |
| ge_th | output | 1 | Fill level at or above thresh |
| wr_par_err | output | 1 | Supplied parity mismatches data (held 0 when par_gen = 1) |

## Verification
A corrupted write pointer or a missed arm flag shows at the write side in the same cycle, as a wrong `eq_th`/`ge_th` or `full`, because these flags are compared against a reference count after every write. A pointer that is wrong across the crossing shows a few read-clock cycles later. Either `empty` stays set, or the head word or its parity differs from the scoreboard. A write that should have been dropped, when full, blocked or not yet armed, appears as an extra or out-of-order word when the FIFO is drained.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

   localparam int unsigned PTR_MAX_W = 32;

   function automatic logic [PTR_MAX_W-1:0] bin2gray(input logic [PTR_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PTR_MAX_W-1:0] gray2bin(input logic [PTR_MAX_W-1:0] g);
      logic [PTR_MAX_W-1:0] b;
      b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
      for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("afifo_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
   parameter int unsigned WORD_W = 9,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
   import afifo_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned HAS_PARITY = 1,
   localparam int unsigned PW        = ADDR_W + 1,
   localparam int unsigned WORD_W    = DATA_W + HAS_PARITY
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              wr_blk_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_par,
   input  logic              par_gen,
   input  logic [PW-1:0]     thresh,
   input  logic [PW-1:0]     rgray_sync,
   output logic [PW-1:0]     wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              we,
   output logic [WORD_W-1:0] wword,
   output logic              full,
   output logic              eq_th,
   output logic              ge_th,
   output logic              wr_par_err
);
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

   logic          strobe_hi;
   logic          armed;
   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nx;
   logic [PW-1:0] rbin_w;
   logic [PW-1:0] fill;

   assign strobe_hi = wr_n | wr_blk_n;

   // arm on the first inactive strobe seen after reset
   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (strobe_hi) armed <= 1'b1;
   end

   assign we      = ~strobe_hi & armed & ~full;
   assign wbin_nx = wbin + PW'(we);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= PW'(bin2gray(PTR_MAX_W'(wbin_nx)));
      end
   end

   assign waddr  = wbin[ADDR_W-1:0];
   assign rbin_w = PW'(gray2bin(PTR_MAX_W'(rgray_sync)));
   assign fill   = wbin - rbin_w;
   assign full   = (fill == DEPTH_V);
   assign eq_th  = (fill == thresh);
   assign ge_th  = (fill >= thresh);

   if (HAS_PARITY != 0) begin : g_par
      logic data_xor;
      assign data_xor   = ^wr_data;
      assign wword      = {(par_gen ? data_xor : wr_par), wr_data};
      assign wr_par_err = ~par_gen & (data_xor ^ wr_par);
   end else begin : g_nopar
      logic unused_par;
      assign unused_par = wr_par ^ par_gen;
      assign wword      = wr_data;
      assign wr_par_err = 1'b0;
   end

   assert_full_holds_ptr_R3: assert property (@(posedge wclk) disable iff (!rst_n)
      full |=> $stable(wbin));
   assert_unarmed_no_write_R7: assert property (@(posedge wclk) disable iff (!rst_n)
      !armed |=> $stable(wbin));
   assert_blocked_no_write_R2: assert property (@(posedge wclk) disable iff (!rst_n)
      strobe_hi |=> $stable(wbin));
   assert_fill_bounded_R5: assert property (@(posedge wclk) disable iff (!rst_n)
      fill <= DEPTH_V);
   assert_eq_implies_ge_R6: assert property (@(posedge wclk) disable iff (!rst_n)
      eq_th |-> ge_th);
   assert_gen_err_quiet_R8: assert property (@(posedge wclk) disable iff (!rst_n)
      par_gen |-> !wr_par_err);
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
   import afifo_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned PW    = ADDR_W + 1
) (
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic [PW-1:0]     wgray_sync,
   output logic [PW-1:0]     rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic              empty
);
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

   logic          pop;
   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nx;
   logic [PW-1:0] wbin_r;

   assign empty   = (rgray == wgray_sync);
   assign pop     = ~rd_n & ~empty;
   assign rbin_nx = rbin + PW'(pop);

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= PW'(bin2gray(PTR_MAX_W'(rbin_nx)));
      end
   end

   assign raddr  = rbin[ADDR_W-1:0];
   assign wbin_r = PW'(gray2bin(PTR_MAX_W'(wgray_sync)));

   assert_empty_no_pop_R4: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |=> $stable(rbin));
   assert_read_level_bounded_R1: assert property (@(posedge rclk) disable iff (!rst_n)
      (wbin_r - rbin) <= DEPTH_V);
endmodule

// File: rtl/afifo_thresh.sv
module afifo_thresh #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HAS_PARITY  = 1
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              wr_blk_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_par,
   input  logic              par_gen,
   input  logic [ADDR_W:0]   thresh,
   input  logic              rd_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_par,
   output logic              empty,
   output logic              full,
   output logic              eq_th,
   output logic              ge_th,
   output logic              wr_par_err
);
   localparam int unsigned PW     = ADDR_W + 1;
   localparam int unsigned WORD_W = DATA_W + HAS_PARITY;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("afifo_thresh: ADDR_W must be 2..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("afifo_thresh: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("afifo_thresh: SYNC_STAGES must be at least 2");
   end
   if (HAS_PARITY > 1) begin : g_bad_par
      $error("afifo_thresh: HAS_PARITY must be 0 or 1");
   end

   logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              we;
   logic [WORD_W-1:0] wword, rword;

   afifo_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wr_n(wr_n), .wr_blk_n(wr_blk_n),
      .wr_data(wr_data), .wr_par(wr_par), .par_gen(par_gen), .thresh(thresh),
      .rgray_sync(rgray_ws), .wgray(wgray), .waddr(waddr), .we(we),
      .wword(wword), .full(full), .eq_th(eq_th), .ge_th(ge_th),
      .wr_par_err(wr_par_err)
   );

   afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .rd_n(rd_n), .wgray_sync(wgray_rs),
      .rgray(rgray), .raddr(raddr), .empty(empty)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
   );

   afifo_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(wword),
      .raddr(raddr), .rdata(rword)
   );

   assign rd_data = rword[DATA_W-1:0];

   if (HAS_PARITY != 0) begin : g_rpar
      assign rd_par = rword[WORD_W-1];
   end else begin : g_rnopar
      assign rd_par = 1'b0;
   end

   assert_flags_consistent_R5: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> (ge_th || (thresh > PW'(1 << ADDR_W))));
endmodule

// File: tb/afifo_thresh_tb.sv
module afifo_thresh_tb;
   localparam int DW    = 8;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          wclk = 0, rclk = 0, rst_n = 0;
   logic          wr_n = 1, wr_blk_n = 1, wr_par = 0, par_gen = 1, rd_n = 1;
   logic [DW-1:0] wr_data = '0;
   logic [AW:0]   thresh = '0;
   logic [DW-1:0] rd_data;
   logic          rd_par, empty, full, eq_th, ge_th, wr_par_err;

   int n_checks = 0, n_fail = 0;
   logic [DW:0] sb [$];

   always #2    wclk = ~wclk;
   always #2.65 rclk = ~rclk;

   afifo_thresh #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .wr_blk_n(wr_blk_n),
      .wr_data(wr_data), .wr_par(wr_par), .par_gen(par_gen), .thresh(thresh),
      .rd_n(rd_n), .rd_data(rd_data), .rd_par(rd_par), .empty(empty),
      .full(full), .eq_th(eq_th), .ge_th(ge_th), .wr_par_err(wr_par_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops scoreboard when a read is being applied to a non-empty FIFO
   always @(negedge rclk) begin
      if (rst_n && !rd_n && !empty) begin
         if (sb.size() == 0) begin
            check(0, "R1 unexpected word", {23'd0, rd_par, rd_data}, 32'd0);
         end else begin
            logic [DW:0] e;
            e = sb.pop_front();
            check({rd_par, rd_data} === e, "R1/R8/R9 head word",
                  {23'd0, rd_par, rd_data}, {23'd0, e});
         end
      end
   end

   task automatic wsettle();
      repeat (6) @(posedge rclk);
      repeat (6) @(posedge wclk);
   endtask

   task automatic flag_check(input string req);
      int lvl;
      @(negedge wclk);
      lvl = sb.size();
      check(full  == (lvl == DEPTH),  {req, " full"},  {31'd0, full},  {31'd0, lvl == DEPTH});
      check(eq_th == (lvl == thresh), {req, " eq_th"}, {31'd0, eq_th}, {31'd0, lvl == thresh});
      check(ge_th == (lvl >= thresh), {req, " ge_th"}, {31'd0, ge_th}, {31'd0, lvl >= thresh});
   endtask

   // driver: one-cycle write strobe; expected word queued only if there is room
   task automatic wr_word(input logic [DW-1:0] d, input logic p);
      @(posedge wclk); #1;
      wr_data = d; wr_par = p; wr_n = 0; wr_blk_n = 0;
      if (sb.size() < DEPTH) sb.push_back({(par_gen ? ^d : p), d});
      @(posedge wclk); #1;
      wr_n = 1;
      flag_check("R6");
   endtask

   task automatic rd_word();
      int t = 0;
      @(negedge rclk);
      while (empty && t < 20) begin @(negedge rclk); t++; end
      check(!empty, "R1 data arrival", {31'd0, empty}, 32'd0);
      @(posedge rclk); #1 rd_n = 0;
      @(posedge rclk); #1 rd_n = 1;
   endtask

   task automatic do_reset();
      rst_n = 0;
      sb.delete();
      repeat (3) @(posedge wclk);
      #1 rst_n = 1;
   endtask

   initial begin : watchdog
      #400000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      repeat (2) @(posedge wclk);
      @(negedge wclk);
      check(empty == 1, "R4 reset empty", {31'd0, empty}, 32'd1);
      check(full == 0,  "R5 reset full",  {31'd0, full},  32'd0);
      check(eq_th == 1 && ge_th == 1, "R6 reset level 0 vs thresh 0",
            {30'd0, eq_th, ge_th}, 32'd3);
      check(wr_par_err == 0, "R8 err low with par_gen", {31'd0, wr_par_err}, 32'd0);

      // R1, R6, R8: ordered data with generated parity
      thresh = 3;
      for (int i = 0; i < 5; i++) wr_word(8'h10 + 8'(i * 7), 1'b0);
      for (int i = 0; i < 5; i++) rd_word();
      wsettle();

      // R2: one of the two strobes high writes nothing
      @(posedge wclk); #1 wr_n = 0; wr_blk_n = 1;
      repeat (3) @(posedge wclk);
      #1 wr_n = 1; wr_blk_n = 0;
      repeat (3) @(posedge wclk);
      #1 wr_blk_n = 1;
      thresh = 1;
      wsettle();
      @(negedge wclk);
      check(ge_th == 0, "R2 blocked strobe wrote", {31'd0, ge_th}, 32'd0);
      @(negedge rclk);
      check(empty == 1, "R2 empty after blocked", {31'd0, empty}, 32'd1);

      // R8 / R9: parity modes
      @(negedge wclk);
      wr_data = 8'h03; wr_par = 1; par_gen = 0; #0.5;
      check(wr_par_err == 1, "R9 mismatch flagged", {31'd0, wr_par_err}, 32'd1);
      wr_par = 0; #0.5;
      check(wr_par_err == 0, "R9 match clean", {31'd0, wr_par_err}, 32'd0);
      par_gen = 1; wr_par = 1; #0.5;
      check(wr_par_err == 0, "R8 err held low", {31'd0, wr_par_err}, 32'd0);
      par_gen = 0;
      wr_word(8'h01, 1'b0);
      wr_word(8'h81, 1'b1);
      rd_word(); rd_word();
      par_gen = 1;
      wsettle();

      // R5, R3, R10: fill, overflow attempt, free one, refill
      thresh = DEPTH;
      for (int i = 0; i < DEPTH; i++) wr_word(8'hA0 ^ 8'(i), 1'b0);
      wr_word(8'hEE, 1'b0);
      check(full == 1, "R3 still full", {31'd0, full}, 32'd1);
      rd_word();
      repeat (4) @(posedge wclk);
      @(negedge wclk);
      check(full == 0, "R10 full cleared", {31'd0, full}, 32'd0);
      wr_word(8'h3C, 1'b0);
      check(full == 1, "R10 write accepted", {31'd0, full}, 32'd1);
      for (int i = 0; i < DEPTH; i++) rd_word();
      @(negedge rclk);
      check(empty == 1, "R4 empty after drain", {31'd0, empty}, 32'd1);
      check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 32'd0);
      wsettle();

      // R4: read while empty has no effect
      @(posedge rclk); #1 rd_n = 0;
      repeat (5) @(posedge rclk);
      #1 rd_n = 1;
      thresh = 1;
      wr_word(8'h5A, 1'b0);
      rd_word();
      wsettle();
      check(sb.size() == 0, "R4 word after empty read", sb.size(), 32'd0);

      // R7: strobe held low through reset release
      @(posedge wclk); #1 wr_n = 0; wr_blk_n = 0; wr_data = 8'h99;
      do_reset();
      repeat (10) @(posedge wclk);
      #1 wr_n = 1;
      wsettle();
      @(negedge wclk);
      check(ge_th == 0, "R7 no write before arm", {31'd0, ge_th}, 32'd0);
      @(negedge rclk);
      check(empty == 1, "R7 empty after held strobe", {31'd0, empty}, 32'd1);
      wr_word(8'h77, 1'b0);
      rd_word();
      wsettle();
      check(sb.size() == 0, "R7 armed write delivered", sb.size(), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule